// File: doc/BRIEF.md
# Byte-Stream Packet Receiver with CRC-32 Trailer Check

This block takes packets arriving one byte per cycle from a streaming port: each byte comes with a valid strobe, and an end flag marks the final byte of a packet. Every accepted byte goes into an internal receive queue. A downstream consumer drains the queue through a valid/ready read port. The block delivers the bytes unchanged and in order. When checking is enabled, that includes the four checksum bytes at the end of the packet.

Three per-packet status flags travel with the final byte of each packet: checksum mismatch, illegal length and too-short idle gap before the packet. A flag never changes whether the packet is accepted.

A back-pressure output tells the remote sender to pause. It rises when the queue fills past an upper threshold and falls only once the queue has drained below a lower threshold. A configuration input can also force it high at any time.

Top module: `pkt_fifo_rx`

## Requirements
- R1: After reset the read port shows no data (`outValid` low). Every accepted byte appears on `outData` in arrival order. `outLast` is high exactly on the byte that arrived with `rxEop`.
- R2: With `cfgCrcCheck` high, the last four bytes of each packet (the checksum) are still delivered as ordinary data bytes.
- R3: With `cfgCrcCheck` high, the checksum uses the CRC-32 generator 0x04C11DB7 with bytes entering bit 0 first and the register preset to all ones. The last four bytes of the packet are the complemented checksum, lowest byte first. `outCrcErr` is set on the final byte when the register run over the whole packet, trailer included, differs from the residue 0xC704DD7B (in the generator's bit order).
- R4: With `cfgCrcCheck` low, `outCrcErr` is 0 even when the trailer is wrong.
- R5: `outLenErr` is set on the final byte when the packet holds fewer than 10 or more than 9600 bytes. The count includes the trailer.
- R6: `outGapErr` is set on the final byte of a packet whose first byte came after fewer than 3 idle cycles following the previous packet's final byte. The packet is still accepted in full. The first packet after reset is never flagged.
- R7: `bpOut` is high from the cycle after the queue level reaches 24 entries (upper threshold).
- R8: Once raised by the level, `bpOut` stays high while the level is 8 or more. It falls in the cycle after the level drops below 8 (lower threshold), unless it is forced.
- R9: `cfgForceBp` high drives `bpOut` high in the same cycle, whatever the level.
- R10: The queue holds 32 entries. A byte that arrives while it is full is discarded, the level never exceeds 32, and reception resumes normally afterwards.
- R11: The three status flags are 0 on every byte that is not the final byte of a packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxData | input | 8 | Incoming byte |
| rxValid | input | 1 | `rxData` carries a byte this cycle |
| rxEop | input | 1 | This byte ends the packet |
| cfgCrcCheck | input | 1 | Treat the last four bytes as a checksum and check them |
| cfgForceBp | input | 1 | Force back-pressure high |
| bpOut | output | 1 | Back-pressure toward the remote sender |
| outData | output | 8 | Byte at the head of the queue |
| outValid | output | 1 | Queue not empty |
| outReady | input | 1 | Consumer takes the head byte this cycle |
| outLast | output | 1 | Head byte ends its packet |
| outCrcErr | output | 1 | Checksum mismatch (final byte only) |
| outLenErr | output | 1 | Length out of range (final byte only) |
| outGapErr | output | 1 | Idle gap too short before this packet (final byte only) |

## Verification
The checker module watches the back-pressure line on every cycle. It checks that the line rises after the level reaches the upper threshold, holds while the level stays at or above the lower one, falls after the level drops below it, and follows the force input at once. On every cycle it also checks that the level never exceeds the queue depth, that an empty queue shows no data, and that status flags appear only on final bytes. The checksum result, the length limits at 9/10 and 9600/9601 bytes, the gap limit at 2/3 idle cycles, byte order with the trailer preserved, and the discarding of bytes into a full queue depend on whole packets. Only the bench's scoreboard scenarios can show those.

// File: rtl/pkt_fifo_rx_pkg.sv
package pkt_fifo_rx_pkg;

  localparam int BYTE_W = 8;

  // Strobes from control to datapath, valid in the cycle of the incoming byte.
  typedef struct packed {
    logic byteIn;   // a byte is present (advances the checksum)
    logic wrEn;     // byte is written into the queue
    logic sop;      // first byte of a packet
    logic last;     // final byte of a packet
    logic lenErr;   // length flag for the final byte
    logic gapErr;   // gap flag for the final byte
  } rxStrobes_t;

  typedef struct packed {
    logic [BYTE_W-1:0] data;
    logic              last;
    logic              crcErr;
    logic              lenErr;
    logic              gapErr;
  } fifoEntry_t;

  // Reflected CRC-32 update, one byte, bit 0 first.
  function automatic logic [31:0] crcStep(input logic [31:0] c, input logic [BYTE_W-1:0] d);
    logic [31:0] r;
    r = c ^ {{(32-BYTE_W){1'b0}}, d};
    for (int k = 0; k < BYTE_W; k++) begin
      r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    end
    return r;
  endfunction

  function automatic logic [31:0] bitRev32(input logic [31:0] v);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = v[31-i];
    return r;
  endfunction

endpackage

// File: rtl/pkt_fifo_rx_ctrl.sv
module pkt_fifo_rx_ctrl
  import pkt_fifo_rx_pkg::*;
#(
  parameter int DEPTH   = 32,
  parameter int HIGH_WM = 24,
  parameter int LOW_WM  = 8,
  parameter int MIN_LEN = 10,
  parameter int MAX_LEN = 9600,
  parameter int MIN_GAP = 3,
  parameter int LVL_W   = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxValid,
  input  logic             rxEop,
  input  logic             cfgForceBp,
  input  logic [LVL_W-1:0] level,
  output rxStrobes_t       strobes,
  output logic             bpOut
);

  localparam int LEN_W = $clog2(MAX_LEN + 2);
  localparam int GAP_W = $clog2(MIN_GAP + 1);
  localparam logic [LEN_W-1:0] LEN_CAP = LEN_W'(MAX_LEN + 1);
  localparam logic [GAP_W-1:0] GAP_SAT = GAP_W'(MIN_GAP);

  logic             inPacket;
  logic [GAP_W-1:0] idleCnt;
  logic [LEN_W-1:0] lenCnt;
  logic [LEN_W-1:0] lenNow;
  logic             gapFlag;
  logic             gapNow;
  logic             sop;
  logic             full;
  logic             wmState;
  logic             lenBad;

  assign sop    = rxValid && !inPacket;
  assign full   = (level == LVL_W'(DEPTH));
  assign gapNow = (idleCnt < GAP_SAT);

  // Running byte count of the current packet, saturating above the maximum.
  always_comb begin
    if (sop)                    lenNow = LEN_W'(1);
    else if (lenCnt == LEN_CAP) lenNow = LEN_CAP;
    else                        lenNow = lenCnt + LEN_W'(1);
  end

  assign lenBad = (lenNow < LEN_W'(MIN_LEN)) || (lenNow > LEN_W'(MAX_LEN));

  always_comb begin
    strobes.byteIn = rxValid;
    strobes.wrEn   = rxValid && !full;
    strobes.sop    = sop;
    strobes.last   = rxValid && rxEop;
    strobes.lenErr = rxValid && rxEop && lenBad;
    strobes.gapErr = rxValid && rxEop && (sop ? gapNow : gapFlag);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inPacket <= 1'b0;
      idleCnt  <= GAP_SAT;
      lenCnt   <= '0;
      gapFlag  <= 1'b0;
    end else begin
      if (rxValid) begin
        inPacket <= !rxEop;
        lenCnt   <= lenNow;
      end
      if (sop) gapFlag <= gapNow;
      if (rxValid && rxEop)
        idleCnt <= '0;
      else if (!rxValid && !inPacket && idleCnt != GAP_SAT)
        idleCnt <= idleCnt + GAP_W'(1);
    end
  end

  // Level-driven back-pressure with hysteresis.
  always_ff @(posedge clk) begin
    if (!rstN)                          wmState <= 1'b0;
    else if (level >= LVL_W'(HIGH_WM))  wmState <= 1'b1;
    else if (level <  LVL_W'(LOW_WM))   wmState <= 1'b0;
  end

  assign bpOut = cfgForceBp || wmState;

endmodule

// File: rtl/pkt_fifo_rx_datapath.sv
module pkt_fifo_rx_datapath
  import pkt_fifo_rx_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int LVL_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxStrobes_t        strobes,
  input  logic [BYTE_W-1:0] rxData,
  input  logic              cfgCrcCheck,
  input  logic              outReady,
  output logic [BYTE_W-1:0] outData,
  output logic              outValid,
  output logic              outLast,
  output logic              outCrcErr,
  output logic              outLenErr,
  output logic              outGapErr,
  output logic [LVL_W-1:0]  level
);

  localparam int PTR_W = $clog2(DEPTH);
  localparam logic [31:0] CRC_RESIDUE = 32'hC704DD7B;

  logic [31:0] crcReg;
  logic [31:0] crcBase;
  logic [31:0] crcNext;
  logic        crcBad;

  fifoEntry_t  mem [DEPTH];
  fifoEntry_t  wrEntry;
  fifoEntry_t  headEntry;
  logic [PTR_W:0] wrPtr;
  logic [PTR_W:0] rdPtr;
  logic        pop;

  // Checksum runs over every byte of the packet, trailer included.
  assign crcBase = strobes.sop ? 32'hFFFFFFFF : crcReg;
  assign crcNext = crcStep(crcBase, rxData);
  assign crcBad  = cfgCrcCheck && strobes.last && (bitRev32(crcNext) != CRC_RESIDUE);

  always_ff @(posedge clk) begin
    if (!rstN)               crcReg <= 32'hFFFFFFFF;
    else if (strobes.byteIn) crcReg <= crcNext;
  end

  always_comb begin
    wrEntry.data   = rxData;
    wrEntry.last   = strobes.last;
    wrEntry.crcErr = crcBad;
    wrEntry.lenErr = strobes.lenErr;
    wrEntry.gapErr = strobes.gapErr;
  end

  always_ff @(posedge clk) begin
    if (strobes.wrEn) mem[wrPtr[PTR_W-1:0]] <= wrEntry;
  end

  assign level    = LVL_W'(wrPtr - rdPtr);
  assign outValid = (wrPtr != rdPtr);
  assign pop      = outValid && outReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strobes.wrEn) wrPtr <= wrPtr + 1'b1;
      if (pop)          rdPtr <= rdPtr + 1'b1;
    end
  end

  assign headEntry = mem[rdPtr[PTR_W-1:0]];

  always_comb begin
    outData   = headEntry.data;
    outLast   = outValid && headEntry.last;
    outCrcErr = outValid && headEntry.crcErr;
    outLenErr = outValid && headEntry.lenErr;
    outGapErr = outValid && headEntry.gapErr;
  end

endmodule

// File: rtl/pkt_fifo_rx.sv
module pkt_fifo_rx
  import pkt_fifo_rx_pkg::*;
#(
  parameter int DEPTH   = 32,   // power of two
  parameter int HIGH_WM = 24,
  parameter int LOW_WM  = 8,
  parameter int MIN_LEN = 10,
  parameter int MAX_LEN = 9600,
  parameter int MIN_GAP = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] rxData,
  input  logic       rxValid,
  input  logic       rxEop,
  input  logic       cfgCrcCheck,
  input  logic       cfgForceBp,
  output logic       bpOut,
  output logic [7:0] outData,
  output logic       outValid,
  input  logic       outReady,
  output logic       outLast,
  output logic       outCrcErr,
  output logic       outLenErr,
  output logic       outGapErr
);

  localparam int LVL_W = $clog2(DEPTH) + 1;

  rxStrobes_t       strobes;
  logic [LVL_W-1:0] fillLevel;

  pkt_fifo_rx_ctrl #(
    .DEPTH(DEPTH), .HIGH_WM(HIGH_WM), .LOW_WM(LOW_WM),
    .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN), .MIN_GAP(MIN_GAP), .LVL_W(LVL_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxEop(rxEop),
    .cfgForceBp(cfgForceBp), .level(fillLevel), .strobes(strobes), .bpOut(bpOut)
  );

  pkt_fifo_rx_datapath #(
    .DEPTH(DEPTH), .LVL_W(LVL_W)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .rxData(rxData),
    .cfgCrcCheck(cfgCrcCheck), .outReady(outReady), .outData(outData),
    .outValid(outValid), .outLast(outLast), .outCrcErr(outCrcErr),
    .outLenErr(outLenErr), .outGapErr(outGapErr), .level(fillLevel)
  );

endmodule

// File: rtl/pkt_fifo_rx_checker.sv
module pkt_fifo_rx_checker #(
  parameter int DEPTH   = 32,
  parameter int HIGH_WM = 24,
  parameter int LOW_WM  = 8,
  parameter int LVL_W   = 6
) (
  input logic             clk,
  input logic             rstN,
  input logic             cfgForceBp,
  input logic             bpOut,
  input logic             outValid,
  input logic             outLast,
  input logic             outCrcErr,
  input logic             outLenErr,
  input logic             outGapErr,
  input logic [LVL_W-1:0] level
);

  assert_level_bound_R10: assert property (@(posedge clk) disable iff (!rstN)
    level <= LVL_W'(DEPTH));

  assert_empty_no_data_R1: assert property (@(posedge clk) disable iff (!rstN)
    (level == '0) |-> !outValid);

  assert_bp_rise_R7: assert property (@(posedge clk) disable iff (!rstN)
    (level >= LVL_W'(HIGH_WM)) |=> bpOut);

  assert_bp_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (bpOut && !cfgForceBp && level >= LVL_W'(LOW_WM)) |=> bpOut);

  assert_bp_fall_R8: assert property (@(posedge clk) disable iff (!rstN)
    (level < LVL_W'(LOW_WM)) |=> (!bpOut || cfgForceBp));

  assert_force_R9: assert property (@(posedge clk) disable iff (!rstN)
    cfgForceBp |-> bpOut);

  assert_flags_on_last_R11: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outLast) |-> !(outCrcErr || outLenErr || outGapErr));

endmodule

bind pkt_fifo_rx pkt_fifo_rx_checker #(
  .DEPTH(DEPTH), .HIGH_WM(HIGH_WM), .LOW_WM(LOW_WM), .LVL_W(LVL_W)
) u_checker (
  .clk(clk), .rstN(rstN), .cfgForceBp(cfgForceBp), .bpOut(bpOut),
  .outValid(outValid), .outLast(outLast), .outCrcErr(outCrcErr),
  .outLenErr(outLenErr), .outGapErr(outGapErr), .level(fillLevel)
);

// File: tb/test_pkt_fifo_rx.sv
module test_pkt_fifo_rx;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 32;

  logic       clk = 1'b0;
  logic       rstN;
  logic [7:0] rxData;
  logic       rxValid, rxEop, cfgCrcCheck, cfgForceBp, outReady;
  logic       bpOut, outValid, outLast, outCrcErr, outLenErr, outGapErr;
  logic [7:0] outData;

  pkt_fifo_rx i_pkt_fifo_rx (
    .clk(clk), .rstN(rstN), .rxData(rxData), .rxValid(rxValid), .rxEop(rxEop),
    .cfgCrcCheck(cfgCrcCheck), .cfgForceBp(cfgForceBp), .bpOut(bpOut),
    .outData(outData), .outValid(outValid), .outReady(outReady),
    .outLast(outLast), .outCrcErr(outCrcErr), .outLenErr(outLenErr),
    .outGapErr(outGapErr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct packed {
    logic [7:0] d;
    logic last, crcE, lenE, gapE;
  } exp_t;

  exp_t expQ[$];
  int   compared   = 0;
  int   mismatched = 0;
  int   idleRun    = 3;
  bit   pktOpen    = 0;
  bit   curGap     = 0;

  task automatic check(input bit ok, input string what, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // Reference checksum, bit by bit.
  function automatic logic [31:0] refCrc(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r = c;
    for (int k = 0; k < 8; k++) begin
      logic fb = r[0] ^ d[k];
      r = r >> 1;
      if (fb) r = r ^ 32'hEDB88320;
    end
    return r;
  endfunction

  // Scoreboard monitor.
  always @(negedge clk) begin
    if (rstN === 1'b1 && outValid && outReady) begin
      exp_t e;
      if (expQ.size() == 0) begin
        check(1'b0, "R1 unexpected output byte", int'(outData), -1);
      end else begin
        e = expQ.pop_front();
        check(outData == e.d,      "R1 R2 data byte",   int'(outData),   int'(e.d));
        check(outLast == e.last,   "R1 last marker",    int'(outLast),   int'(e.last));
        check(outCrcErr == e.crcE, "R3 R4 crc flag",    int'(outCrcErr), int'(e.crcE));
        check(outLenErr == e.lenE, "R5 length flag",    int'(outLenErr), int'(e.lenE));
        check(outGapErr == e.gapE, "R6 gap flag",       int'(outGapErr), int'(e.gapE));
      end
    end
  end

  task automatic tick();
    logic v;
    v = rxValid;
    @(posedge clk);
    #1;
    if (!v && !pktOpen && idleRun < 3) idleRun++;
  endtask

  task automatic driveByte(input logic [7:0] d, input bit eop, input bit crcE,
                           input bit lenE, input bit push);
    exp_t e;
    if (!pktOpen) curGap = (idleRun < 3);
    rxData  = d;
    rxValid = 1'b1;
    rxEop   = eop;
    e.d = d; e.last = eop;
    e.crcE = eop && crcE; e.lenE = eop && lenE; e.gapE = eop && curGap;
    if (push) expQ.push_back(e);
    tick();
    rxValid = 1'b0;
    rxEop   = 1'b0;
    if (eop) begin pktOpen = 0; idleRun = 0; end
    else pktOpen = 1;
  endtask

  task automatic sendPkt(input int len, input bit corrupt, input int gap, input bit trailer);
    logic [31:0] crc = 32'hFFFFFFFF;
    logic [31:0] fcs;
    bit lenE = (len < 10) || (len > 9600);
    bit crcE = cfgCrcCheck && corrupt;
    int nPay = trailer ? len - 4 : len;
    repeat (gap) tick();
    for (int i = 0; i < nPay; i++) begin
      logic [7:0] b = 8'((i * 7 + len) & 8'hFF);
      crc = refCrc(crc, b);
      driveByte(b, (i == len - 1), crcE, lenE, 1'b1);
    end
    if (trailer) begin
      fcs = ~crc;
      for (int k = 0; k < 4; k++) begin
        logic [7:0] b = fcs[8*k +: 8];
        if (k == 0 && corrupt) b = b ^ 8'h01;
        driveByte(b, (k == 3), crcE, lenE, 1'b1);
      end
    end
  endtask

  task automatic drain();
    int n = 0;
    while (expQ.size() > 0 && n < 30000) begin tick(); n++; end
    tick(); tick();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    rstN = 1'b0; rxData = '0; rxValid = 0; rxEop = 0;
    cfgCrcCheck = 0; cfgForceBp = 0; outReady = 1'b1;
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    check(outValid == 1'b0, "R1 reset empty", int'(outValid), 0);
    check(bpOut == 1'b0,    "R7 reset back-pressure low", int'(bpOut), 0);

    // R6: first packet after reset, no idle cycles, not flagged
    sendPkt(12, 0, 0, 0);
    drain();

    // R2 R3: checksum on, good and bad trailers, minimum length with trailer
    cfgCrcCheck = 1'b1;
    sendPkt(64, 0, 5, 1);
    sendPkt(64, 1, 5, 1);
    sendPkt(10, 0, 5, 1);
    sendPkt(10, 1, 5, 1);
    drain();

    // R4: checksum off, wrong trailer ignored
    cfgCrcCheck = 1'b0;
    sendPkt(20, 1, 5, 1);
    drain();

    // R5: length boundaries
    sendPkt(9, 0, 5, 0);
    sendPkt(10, 0, 5, 0);
    sendPkt(1, 0, 5, 0);
    drain();
    cfgCrcCheck = 1'b1;
    sendPkt(9600, 0, 5, 1);
    drain();
    cfgCrcCheck = 1'b0;
    sendPkt(9601, 0, 5, 0);
    drain();

    // R6: gap of 2 flagged, 3 accepted clean, back-to-back flagged
    sendPkt(12, 0, 5, 0);
    sendPkt(12, 0, 2, 0);
    sendPkt(12, 0, 3, 0);
    sendPkt(12, 0, 0, 0);
    drain();

    // R7 R8 R9: watermark hysteresis and force
    outReady = 1'b0;
    for (int i = 0; i < 23; i++) driveByte(8'(i), 0, 0, 0, 1);
    tick();
    check(bpOut == 1'b0, "R7 level 23 below threshold", int'(bpOut), 0);
    driveByte(8'd23, 0, 0, 0, 1);
    tick();
    check(bpOut == 1'b1, "R7 level 24 raises back-pressure", int'(bpOut), 1);
    outReady = 1'b1;
    repeat (16) tick();
    outReady = 1'b0;
    tick();
    check(bpOut == 1'b1, "R8 level 8 holds back-pressure", int'(bpOut), 1);
    outReady = 1'b1;
    tick();
    outReady = 1'b0;
    tick();
    check(bpOut == 1'b0, "R8 level 7 releases back-pressure", int'(bpOut), 0);
    cfgForceBp = 1'b1;
    #1;
    check(bpOut == 1'b1, "R9 force raises back-pressure", int'(bpOut), 1);
    cfgForceBp = 1'b0;
    #1;
    check(bpOut == 1'b0, "R9 force released", int'(bpOut), 0);
    for (int i = 24; i < 30; i++) driveByte(8'(i), (i == 29), 0, 0, 1);
    outReady = 1'b1;
    drain();

    // R10: overflow, bytes beyond depth discarded
    outReady = 1'b0;
    repeat (5) tick();
    for (int i = 0; i < 40; i++) driveByte(8'(i + 100), (i == 39), 0, 0, (i < DEPTH));
    tick();
    check(bpOut == 1'b1, "R7 R10 full queue back-pressure", int'(bpOut), 1);
    check(expQ.size() == DEPTH, "R10 expected entries held", expQ.size(), DEPTH);
    outReady = 1'b1;
    drain();
    check(outValid == 1'b0, "R10 only depth entries delivered", int'(outValid), 0);
    check(expQ.size() == 0, "R10 scoreboard drained", expQ.size(), 0);
    sendPkt(16, 0, 5, 0);
    drain();
    check(expQ.size() == 0, "R10 recovery packet delivered", expQ.size(), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule